// File: doc/BRIEF.md
# External Bus Hold Handshake Controller

This block belongs to an external memory interface. It lets an outside device take over the shared external bus. The outside device pulls an active-low request pin low. The controller lets the interface sequencer finish the access in flight and every access already queued. It then turns off the address, data and strobe drivers and pulls its active-low acknowledge low. When the request pin goes back high, the drivers are switched on again. The sequencer is kept stalled for one further cycle, so the first new access starts on a bus that is already driven.

The request pin can also carry a trip-zone signal from another function. A configuration bit therefore lets software make the controller ignore the pin. The request passes through a synchronizer before use. A four-state machine then acts on it.

- **IDLE**: the bus is driven and the sequencer runs freely. It moves to DRAIN when a qualified request is seen.
- **DRAIN**: the bus is still driven and the sequencer may finish its work. It moves to HELD once `seq_busy` and `seq_pend` are both low. It moves back to IDLE if the request goes away first.
- **HELD**: the drivers are off, the acknowledge is low and the sequencer is stalled. It moves to RESUME when the request is withdrawn or disabled.
- **RESUME**: the drivers are back on and the acknowledge is high, while the stall is held for one more cycle. It then moves to IDLE.

Top module: `xbus_hold_ctrl`

## Requirements
- R1: The request pin passes through two flip-flops. With the sequencer idle, the first rising edge that samples `hold_req_n` low is counted as edge 1. After edge 3, `hold_ack_n` is still high. After edge 4, it is low.
- R2: `hold_ack_n` goes low only after a rising edge at which `seq_busy` and `seq_pend` were both sampled low.
- R3: Once the bus has been released, `hold_ack_n` stays low for as long as the synchronized request stays low and the disable bit stays clear.
- R4: While `hold_ack_n` is low, every bit of `bus_oe` is 0, which means the address, data and strobe drivers are in high impedance. At all other times, every bit of `bus_oe` is 1.
- R5: `seq_stall` is 1 in HELD and RESUME. It is 0 in IDLE and DRAIN.
- R6: After the high level on `hold_req_n` has been synchronized, the controller spends exactly one cycle with `hold_ack_n`=1, `bus_oe` all 1 and `seq_stall`=1. After that cycle, `seq_stall` goes to 0.
- R7: While `hold_dis`=1, the request is ignored and `hold_ack_n` is high one cycle after any edge that samples `hold_dis`=1. Setting `hold_dis` during HELD ends the hold through RESUME.
- R8: If the request is withdrawn during DRAIN, the controller returns to IDLE and `hold_ack_n` never goes low.
- R9: During and right after reset, `hold_ack_n`=1, `bus_oe` is all 1 and `seq_stall`=0. The synchronizer resets to the inactive (high) level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req_n | input | 1 | Asynchronous active-low bus hold request from the pin |
| hold_dis | input | 1 | Configuration bit, 1 = ignore the hold request |
| seq_busy | input | 1 | Sequencer has an access in progress |
| seq_pend | input | 1 | Sequencer has at least one queued access |
| hold_ack_n | output | 1 | Active-low hold acknowledge |
| bus_oe | output | OE_LANES (3) | Output enables for the address, data and strobe driver groups |
| seq_stall | output | 1 | Tells the sequencer to start no new access |

## Verification
Two events can meet in a single cycle: the sequencer drains, and the request is withdrawn or disabled. The stimulus table clears `seq_busy` in the same cycle that the synchronized request rises during DRAIN. It also raises `hold_dis` in the cycle right after the grant. The outcome is judged at the ports. In the drain case, the acknowledge must never fall. In the disable case, the hold must end through one RESUME cycle, with the drivers back on and the stall still set.

// File: rtl/xbh_pkg.sv
package xbh_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_HELD   = 2'd2,
        ST_RESUME = 2'd3
    } xbh_state_e;

endpackage

// File: rtl/xbh_sync.sv
module xbh_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= RESET_VAL;
                else        chain <= d_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RESET_VAL}};
                else        chain <= {chain[LAST-1:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain[LAST];
endmodule

// File: rtl/xbh_fsm.sv
module xbh_fsm
    import xbh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic busy,
    input  logic pend,
    output logic ack_n,
    output logic drive,
    output logic stall
);
    xbh_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req) state_d = ST_DRAIN;
            ST_DRAIN: begin
                if (!req)               state_d = ST_IDLE;
                else if (!busy && !pend) state_d = ST_HELD;
            end
            ST_HELD:   if (!req) state_d = ST_RESUME;
            ST_RESUME: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        ack_n = 1'b1;
        drive = 1'b1;
        stall = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DRAIN: begin
                ack_n = 1'b1;
                drive = 1'b1;
                stall = 1'b0;
            end
            ST_HELD: begin
                ack_n = 1'b0;
                drive = 1'b0;
                stall = 1'b1;
            end
            ST_RESUME: begin
                ack_n = 1'b1;
                drive = 1'b1;
                stall = 1'b1;
            end
            default: begin
                ack_n = 1'b1;
                drive = 1'b1;
                stall = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/xbus_hold_ctrl.sv
module xbus_hold_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int OE_LANES    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hold_req_n,
    input  logic                hold_dis,
    input  logic                seq_busy,
    input  logic                seq_pend,
    output logic                hold_ack_n,
    output logic [OE_LANES-1:0] bus_oe,
    output logic                seq_stall
);
    logic req_sync_n;
    logic req_live;
    logic drive_en;

    xbh_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (hold_req_n),
        .q_sync  (req_sync_n)
    );

    assign req_live = ~req_sync_n & ~hold_dis;

    xbh_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req_live),
        .busy  (seq_busy),
        .pend  (seq_pend),
        .ack_n (hold_ack_n),
        .drive (drive_en),
        .stall (seq_stall)
    );

    generate
        for (genvar g = 0; g < OE_LANES; g++) begin : g_lane
            assign bus_oe[g] = drive_en;
        end
    endgenerate
endmodule

// File: rtl/xbh_checker.sv
module xbh_checker #(
    parameter int OE_LANES = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                hold_dis,
    input logic                seq_busy,
    input logic                seq_pend,
    input logic                hold_ack_n,
    input logic [OE_LANES-1:0] bus_oe,
    input logic                seq_stall
);
    AST_ACK_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_ack_n |-> (bus_oe == '0)); // R4

    AST_ACK_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_ack_n) |-> $past(!seq_busy && !seq_pend)); // R2

    AST_HELD_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_ack_n |-> seq_stall); // R5

    AST_RESUME_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack_n) |-> (seq_stall && (bus_oe == '1))); // R6

    AST_RESUME_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack_n) |=> !seq_stall); // R6

    AST_DIS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        hold_dis |=> hold_ack_n); // R7
endmodule

bind xbus_hold_ctrl xbh_checker #(.OE_LANES(OE_LANES)) u_xbh_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_dis   (hold_dis),
    .seq_busy   (seq_busy),
    .seq_pend   (seq_pend),
    .hold_ack_n (hold_ack_n),
    .bus_oe     (bus_oe),
    .seq_stall  (seq_stall)
);

// File: tb/xbus_hold_ctrl_test.sv
module xbus_hold_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 3;
    localparam int NVEC       = 24;

    // {hold_req_n, hold_dis, seq_busy, seq_pend, exp_ack_n, exp_oe, exp_stall}
    localparam logic [6:0] VEC [NVEC] = '{
        7'b1000_110, 7'b0010_110, 7'b0010_110, 7'b0010_110,
        7'b0001_110, 7'b0000_001, 7'b0001_001, 7'b1001_001,
        7'b1000_001, 7'b1000_111, 7'b1001_110, 7'b0100_110,
        7'b0100_110, 7'b0100_110, 7'b0100_110, 7'b0000_110,
        7'b0000_001, 7'b0100_111, 7'b0100_110, 7'b0010_110,
        7'b1010_110, 7'b1010_110, 7'b1000_110, 7'b1000_110
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_req_n = 1'b1;
    logic hold_dis = 1'b0;
    logic seq_busy = 1'b0;
    logic seq_pend = 1'b0;
    logic hold_ack_n;
    logic [LANES-1:0] bus_oe;
    logic seq_stall;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_hold_ctrl #(.SYNC_STAGES(2), .OE_LANES(LANES)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_req_n (hold_req_n),
        .hold_dis   (hold_dis),
        .seq_busy   (seq_busy),
        .seq_pend   (seq_pend),
        .hold_ack_n (hold_ack_n),
        .bus_oe     (bus_oe),
        .seq_stall  (seq_stall)
    );

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {ack_n,oe,stall} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic string vec_tag(input int i);
        if (i < 5)       return "R2 drain wait";
        else if (i < 7)  return "R3 held";
        else if (i < 9)  return "R4 float";
        else if (i < 11) return "R6 resume";
        else if (i < 15) return "R7 disabled";
        else if (i < 17) return "R5 stall";
        else if (i < 19) return "R7 disable in hold";
        else             return "R8 drain abort";
    endfunction

    function automatic logic [4:0] pack(input logic a, input logic o, input logic s);
        return {a, {LANES{o}}, s};
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        #(CLK_PERIOD * 2 + 1);
        check("R9 in reset", {hold_ack_n, bus_oe, seq_stall}, pack(1'b1, 1'b1, 1'b0));
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R9 after reset", {hold_ack_n, bus_oe, seq_stall}, pack(1'b1, 1'b1, 1'b0));

        for (int i = 0; i < NVEC; i++) begin
            hold_req_n = VEC[i][6];
            hold_dis   = VEC[i][5];
            seq_busy   = VEC[i][4];
            seq_pend   = VEC[i][3];
            @(posedge clk); @(negedge clk);
            check($sformatf("%s vec %0d", vec_tag(i), i),
                  {hold_ack_n, bus_oe, seq_stall},
                  pack(VEC[i][2], VEC[i][1], VEC[i][0]));
        end

        // R1: synchronizer latency with an idle sequencer
        hold_req_n = 1'b1; hold_dis = 1'b0; seq_busy = 1'b0; seq_pend = 1'b0;
        repeat (4) @(negedge clk);
        hold_req_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 edge 3 still high", {hold_ack_n, bus_oe, seq_stall}, pack(1'b1, 1'b1, 1'b0));
        @(posedge clk); @(negedge clk);
        check("R1 edge 4 granted", {hold_ack_n, bus_oe, seq_stall}, pack(1'b0, 1'b0, 1'b1));

        // R9: reset while held
        rst_n = 1'b0;
        #1;
        check("R9 reset in hold", {hold_ack_n, bus_oe, seq_stall}, pack(1'b1, 1'b1, 1'b0));
        @(negedge clk);
        hold_req_n = 1'b1;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 idle after reset", {hold_ack_n, bus_oe, seq_stall}, pack(1'b1, 1'b1, 1'b0));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule